// File: doc/BRIEF.md
# Write-Once Store with Parked Reads

This block is a small word-addressed store in which every entry is written exactly once and may then be read any number of times. Each entry carries a presence bit. A read that arrives before its entry has been written gets no data at that moment. Instead, the requester tag is linked onto a per-entry waiting chain built from a shared pool of nodes. When the single write to that entry lands, the engine walks the chain and delivers the value to every waiting requester, one per cycle, each carrying its own tag.

Producers and consumers can therefore run in any order. A consumer never sees stale data, because every answer comes from the one value an entry ever holds. A second write to a filled entry is refused, and it raises a sticky error that holds the address of the first offender. A synchronous clear input returns the whole store to the freshly allocated state.

The block accepts at most one operation per cycle, and a write wins over a read. While a chain is being drained, both request ports are held off, so the response port has a single source in every cycle.

Top module: `istruct_mem`

## Requirements
- R1: After `rst` or `clr`, every entry is empty, all pool nodes are free, `rsp_valid` and `err_dup` are low, `err_addr` is 0 and `wr_ready` is high.
- R2: A read accepted at a clock edge on a filled entry raises `rsp_valid` right after that edge, for one cycle, with `rsp_id` equal to the read's tag and `rsp_data` equal to the stored value.
- R3: A read accepted on an empty entry produces no response until that entry is written.
- R4: A write accepted on an empty entry that has N parked readers gives N responses on N consecutive cycles, the first one visible after the second clock edge counted from acceptance. Each response carries the written value. The tags come out in reverse arrival order, so the most recently parked reader is answered first.
- R5: The value of a filled entry never changes. A later write to that entry leaves what reads return untouched.
- R6: A write accepted on a filled entry sets `err_dup`, which stays high until `rst` or `clr`. `err_addr` latches the address of the first such write only.
- R7: At most POOL reads can be parked at once. With every node in use, `rd_ready` is low for reads of empty entries and stays high for reads of filled entries.
- R8: While a drain is in progress, `wr_ready` and `rd_ready` are both low. `rd_ready` is also low in any cycle in which `wr_valid` is high.
- R9: `clr` discards every parked reader. A write after `clr` answers no reader that was parked before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear back to the allocated state |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request accepted when high with `wr_valid` |
| wr_addr | input | ADDR_W | Entry to fill |
| wr_data | input | DATA_W | Value to store |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request accepted when high with `rd_valid` |
| rd_addr | input | ADDR_W | Entry to read |
| rd_id | input | ID_W | Requester tag |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_id | output | ID_W | Tag of the requester being answered |
| rsp_data | output | DATA_W | Value returned |
| err_dup | output | 1 | Sticky flag: a write hit a filled entry |
| err_addr | output | ADDR_W | Address of the first duplicate write |

## Verification
A presence bit that is wrong shows up one cycle after the next read of that entry. The read either answers at once when it should have parked, or stays silent when it should have answered. A broken chain or free list shows up during the drain that follows the next write. Tags go missing or repeat, the order is wrong, or `rd_ready` stops tracking the number of free nodes. Every answer and every missing answer is therefore matched against a model of the parked readers, and the cycle at which each response appears is checked.

// File: rtl/isx_pkg.sv
`timescale 1ns/1ps
package isx_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_WRITE,
    ACT_HIT,
    ACT_PARK
  } isx_act_e;
endpackage

// File: rtl/isx_mem.sv
`timescale 1ns/1ps
module isx_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    q <= ram[raddr];
  end
endmodule

// File: rtl/isx_dir.sv
`timescale 1ns/1ps
module isx_dir #(
  parameter int ADDR_W = 4,
  parameter int PTR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic [ADDR_W-1:0]         lk_addr,
  input  logic                      set_en,
  input  logic                      park_en,
  input  logic [PTR_W-1:0]          park_node,
  output logic                      lk_full,
  output logic                      lk_has,
  output logic [PTR_W-1:0]          lk_head,
  output logic [(1<<ADDR_W)-1:0]    full_vec
);
  localparam int ENTRIES = 1 << ADDR_W;
  logic [ENTRIES-1:0] full_q;
  logic [ENTRIES-1:0] has_q;
  logic [PTR_W-1:0]   head_q [ENTRIES];

  assign lk_full  = full_q[lk_addr];
  assign lk_has   = has_q[lk_addr];
  assign lk_head  = head_q[lk_addr];
  assign full_vec = full_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      full_q <= '0;
      has_q  <= '0;
    end else if (set_en) begin
      full_q[lk_addr] <= 1'b1;
      has_q[lk_addr]  <= 1'b0;
    end else if (park_en) begin
      has_q[lk_addr]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (park_en) head_q[lk_addr] <= park_node;
  end
endmodule

// File: rtl/isx_pool.sv
`timescale 1ns/1ps
module isx_pool #(
  parameter int POOL  = 8,
  parameter int ID_W  = 4,
  parameter int PTR_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             alloc_en,
  input  logic [ID_W-1:0]  alloc_id,
  input  logic [PTR_W-1:0] alloc_next,
  input  logic             alloc_last,
  input  logic             rel_en,
  input  logic [PTR_W-1:0] rel_idx,
  input  logic [PTR_W-1:0] look_idx,
  output logic [PTR_W-1:0] free_idx,
  output logic             avail,
  output logic [ID_W-1:0]  look_id,
  output logic [PTR_W-1:0] look_next,
  output logic             look_last,
  output logic [CNT_W-1:0] free_cnt
);
  logic [ID_W-1:0]  n_id   [POOL];
  logic [PTR_W-1:0] n_next [POOL];
  logic             n_last [POOL];
  logic [PTR_W-1:0] free_head;
  logic [CNT_W-1:0] cnt_q;

  assign free_idx  = free_head;
  assign avail     = (cnt_q != '0);
  assign free_cnt  = cnt_q;
  assign look_id   = n_id[look_idx];
  assign look_next = n_next[look_idx];
  assign look_last = n_last[look_idx];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < POOL; i++) n_next[i] <= PTR_W'((i + 1) % POOL);
      free_head <= '0;
      cnt_q     <= CNT_W'(POOL);
    end else if (alloc_en) begin
      free_head         <= n_next[free_head];
      n_next[free_head] <= alloc_next;
      cnt_q             <= cnt_q - 1'b1;
    end else if (rel_en) begin
      n_next[rel_idx] <= free_head;
      free_head       <= rel_idx;
      cnt_q           <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      n_id[free_head]   <= alloc_id;
      n_last[free_head] <= alloc_last;
    end
  end
endmodule

// File: rtl/istruct_mem.sv
`timescale 1ns/1ps
module istruct_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int ID_W   = 4,
  parameter int POOL   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ID_W-1:0]   rd_id,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  output logic [DATA_W-1:0] rsp_data,
  output logic              err_dup,
  output logic [ADDR_W-1:0] err_addr
);
  import isx_pkg::*;
  localparam int ENTRIES = 1 << ADDR_W;
  localparam int PTR_W   = (POOL > 1) ? $clog2(POOL) : 1;
  localparam int CNT_W   = $clog2(POOL + 1);

  logic [ADDR_W-1:0]  op_addr;
  logic               lk_full, lk_has;
  logic [PTR_W-1:0]   lk_head;
  logic [ENTRIES-1:0] dir_full_vec;
  logic [PTR_W-1:0]   pl_free_idx, pl_next;
  logic               pl_avail, pl_last;
  logic [ID_W-1:0]    pl_id;
  logic [CNT_W-1:0]   pool_free_cnt;
  logic [DATA_W-1:0]  mem_q;

  logic               drain_busy;
  logic [PTR_W-1:0]   drain_ptr;
  logic [DATA_W-1:0]  drain_data;
  logic               rsp_from_mem;
  isx_act_e           act;

  assign op_addr  = wr_valid ? wr_addr : rd_addr;
  assign wr_ready = !drain_busy;
  assign rd_ready = !drain_busy && !wr_valid && (lk_full || pl_avail);

  always_comb begin
    act = ACT_IDLE;
    if (wr_valid && wr_ready)      act = ACT_WRITE;
    else if (rd_valid && rd_ready) act = lk_full ? ACT_HIT : ACT_PARK;
  end

  isx_dir #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_dir (
    .clk(clk), .rst(rst), .clr(clr), .lk_addr(op_addr),
    .set_en(act == ACT_WRITE && !lk_full),
    .park_en(act == ACT_PARK), .park_node(pl_free_idx),
    .lk_full(lk_full), .lk_has(lk_has), .lk_head(lk_head),
    .full_vec(dir_full_vec)
  );

  isx_pool #(.POOL(POOL), .ID_W(ID_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_pool (
    .clk(clk), .rst(rst), .clr(clr),
    .alloc_en(act == ACT_PARK), .alloc_id(rd_id),
    .alloc_next(lk_head), .alloc_last(!lk_has),
    .rel_en(drain_busy), .rel_idx(drain_ptr), .look_idx(drain_ptr),
    .free_idx(pl_free_idx), .avail(pl_avail),
    .look_id(pl_id), .look_next(pl_next), .look_last(pl_last),
    .free_cnt(pool_free_cnt)
  );

  isx_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(act == ACT_WRITE && !lk_full),
    .waddr(wr_addr), .wdata(wr_data), .raddr(rd_addr), .q(mem_q)
  );

  assign rsp_data = rsp_from_mem ? mem_q : drain_data;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      drain_busy   <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_from_mem <= 1'b0;
      err_dup      <= 1'b0;
      err_addr     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (drain_busy) begin
        rsp_valid    <= 1'b1;
        rsp_id       <= pl_id;
        rsp_from_mem <= 1'b0;
        if (pl_last) drain_busy <= 1'b0;
        else         drain_ptr  <= pl_next;
      end else begin
        case (act)
          ACT_WRITE: begin
            if (lk_full) begin
              if (!err_dup) begin
                err_dup  <= 1'b1;
                err_addr <= wr_addr;
              end
            end else if (lk_has) begin
              drain_busy <= 1'b1;
              drain_ptr  <= lk_head;
              drain_data <= wr_data;
            end
          end
          ACT_HIT: begin
            rsp_valid    <= 1'b1;
            rsp_id       <= rd_id;
            rsp_from_mem <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/istruct_mem_chk.sv
`timescale 1ns/1ps
module istruct_mem_chk #(
  parameter int ADDR_W = 4,
  parameter int ID_W   = 4,
  parameter int POOL   = 8,
  parameter int CNT_W  = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   clr,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic                   rd_valid,
  input logic                   rd_ready,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic [ID_W-1:0]        rd_id,
  input logic                   rsp_valid,
  input logic [ID_W-1:0]        rsp_id,
  input logic                   err_dup,
  input logic [ADDR_W-1:0]      err_addr,
  input logic [(1<<ADDR_W)-1:0] full_vec,
  input logic [CNT_W-1:0]       free_cnt,
  input logic                   drain_busy
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    (rst || clr) |=> (!rsp_valid && !err_dup && full_vec == '0 && free_cnt == CNT_W'(POOL)));

  a_r2_hit_next: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && full_vec[rd_addr] && !clr) |=> (rsp_valid && rsp_id == $past(rd_id)));

  a_r3_park_silent: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && !full_vec[rd_addr]) |=> !rsp_valid);

  a_r5_full_monotone: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (($past(full_vec) & ~full_vec) == '0));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_dup && !clr) |=> (err_dup && $stable(err_addr)));

  a_r7_pool_bound: assert property (@(posedge clk) disable iff (rst)
    (free_cnt <= CNT_W'(POOL)) && ((free_cnt == '0 && !full_vec[rd_addr]) -> !rd_ready));

  a_r8_drain_blocks: assert property (@(posedge clk) disable iff (rst)
    drain_busy |-> (!wr_ready && !rd_ready));

  a_r8_one_op: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && wr_ready && rd_valid && rd_ready));
endmodule

bind istruct_mem istruct_mem_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .POOL(POOL), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr),
  .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_id(rd_id),
  .rsp_valid(rsp_valid), .rsp_id(rsp_id),
  .err_dup(err_dup), .err_addr(err_addr),
  .full_vec(dir_full_vec), .free_cnt(pool_free_cnt), .drain_busy(drain_busy)
);

// File: tb/sim_istruct_mem.sv
`timescale 1ns/1ps
module sim_istruct_mem;
  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0;
  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0, rd_id = '0;
  logic [15:0] wr_data = '0;
  logic wr_ready, rd_ready, rsp_valid, err_dup;
  logic [3:0]  rsp_id, err_addr;
  logic [15:0] rsp_data;

  int n_chk = 0, n_fail = 0, n_rsp = 0;
  bit done = 0;

  bit          m_full [16];
  logic [15:0] m_data [16];
  int          m_pcnt [16];
  logic [3:0]  m_park [16][8];
  int          m_total;
  bit          m_err;
  logic [3:0]  m_eaddr;
  logic [3:0]  exp_id [$];
  logic [15:0] exp_dat [$];

  always #10 clk = ~clk;

  istruct_mem u0 (
    .clk(clk), .rst(rst), .clr(clr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_id(rd_id),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .err_dup(err_dup), .err_addr(err_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  function automatic void model_clear();
    for (int i = 0; i < 16; i++) begin m_full[i] = 0; m_pcnt[i] = 0; end
    m_total = 0; m_err = 0; m_eaddr = '0;
  endfunction

  function automatic void model_write(input logic [3:0] a, input logic [15:0] d);
    if (m_full[a]) begin
      if (!m_err) begin m_err = 1; m_eaddr = a; end
    end else begin
      m_full[a] = 1; m_data[a] = d;
      for (int k = m_pcnt[a] - 1; k >= 0; k--) begin
        exp_id.push_back(m_park[a][k]); exp_dat.push_back(d);
      end
      m_total -= m_pcnt[a]; m_pcnt[a] = 0;
    end
  endfunction

  function automatic void model_read(input logic [3:0] a, input logic [3:0] id);
    if (m_full[a]) begin
      exp_id.push_back(id); exp_dat.push_back(m_data[a]);
    end else begin
      m_park[a][m_pcnt[a]] = id; m_pcnt[a]++; m_total++;
    end
  endfunction

  // Response monitor: R2, R4 order/tag/data, R3 and R9 silence
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      n_rsp++;
      if (exp_id.size() == 0) chk("R3/R9 unexpected response", {12'h0, rsp_id, rsp_data}, 32'hFFFF_FFFF);
      else begin
        chk("R2/R4 response tag", {28'h0, rsp_id}, {28'h0, exp_id.pop_front()});
        chk("R2/R4 response data", {16'h0, rsp_data}, {16'h0, exp_dat.pop_front()});
      end
    end
  end

  task automatic do_wr(input logic [3:0] a, input logic [15:0] d);
    bit acc = 0;
    int w = 0;
    while (!acc) begin
      @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d; #1;
      acc = wr_ready;
      if (acc) model_write(a, d);
      @(posedge clk); #1 wr_valid = 0;
      w++;
      if (w > 50 && !acc) begin chk("R8 write never accepted", 0, 1); acc = 1; end
    end
  endtask

  task automatic do_rd(input logic [3:0] a, input logic [3:0] id);
    bit acc = 0;
    int w = 0;
    while (!acc) begin
      @(negedge clk); rd_valid = 1; rd_addr = a; rd_id = id; #1;
      acc = rd_ready;
      if (acc) model_read(a, id);
      @(posedge clk); #1 rd_valid = 0;
      w++;
      if (w > 50 && !acc) begin chk("R7 read never accepted", 0, 1); acc = 1; end
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    @(posedge clk); #1 clr = 0;
    model_clear();
  endtask

  initial begin
    #(20 * 150000);
    chk("watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int base;
    model_clear();
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid after reset", {31'h0, rsp_valid}, 0);
    chk("R1 err_dup after reset", {31'h0, err_dup}, 0);
    chk("R1 err_addr after reset", {28'h0, err_addr}, 0);
    chk("R1 wr_ready after reset", {31'h0, wr_ready}, 1);

    // R2 immediate answer one cycle after acceptance
    do_wr(4'd3, 16'hBEEF);
    do_rd(4'd3, 4'd7);
    @(negedge clk);
    chk("R2 hit rsp_valid", {31'h0, rsp_valid}, 1);
    chk("R2 hit rsp_id", {28'h0, rsp_id}, 32'd7);
    chk("R2 hit rsp_data", {16'h0, rsp_data}, 32'hBEEF);

    // R3 parked reads are silent
    do_rd(4'd5, 4'd1); do_rd(4'd5, 4'd2); do_rd(4'd5, 4'd3);
    @(negedge clk);
    chk("R3 no response while empty", {31'h0, rsp_valid}, 0);

    // R4 drain timing and R8 stall
    do_wr(4'd5, 16'h1234);
    @(negedge clk);
    chk("R4 no response first cycle", {31'h0, rsp_valid}, 0);
    chk("R8 wr_ready low during drain", {31'h0, wr_ready}, 0);
    chk("R8 rd_ready low during drain", {31'h0, rd_ready}, 0);
    @(negedge clk); chk("R4 drain beat 1", {31'h0, rsp_valid}, 1);
    @(negedge clk); chk("R4 drain beat 2", {31'h0, rsp_valid}, 1);
    @(negedge clk); chk("R4 drain beat 3", {31'h0, rsp_valid}, 1);
    @(negedge clk);
    chk("R4 drain ends", {31'h0, rsp_valid}, 0);
    chk("R8 wr_ready back", {31'h0, wr_ready}, 1);
    // R8 read held off while a write is offered
    wr_valid = 1; wr_addr = 4'd3; rd_valid = 1; rd_addr = 4'd3; #1;
    chk("R8 rd_ready low with wr_valid", {31'h0, rd_ready}, 0);
    wr_valid = 0; rd_valid = 0;

    // R5/R6 duplicate write
    do_wr(4'd5, 16'h9999);
    @(negedge clk);
    chk("R6 err_dup set", {31'h0, err_dup}, 1);
    chk("R6 err_addr first", {28'h0, err_addr}, 32'd5);
    do_wr(4'd3, 16'h5555);
    do_rd(4'd5, 4'd9);
    @(negedge clk);
    chk("R5 value unchanged", {16'h0, rsp_data}, 32'h1234);
    chk("R6 err_addr kept", {28'h0, err_addr}, 32'd5);

    // R7 pool exhaustion
    for (int i = 0; i < 8; i++) do_rd(4'd9, 4'(i));
    @(negedge clk);
    rd_valid = 1; rd_addr = 4'd9; rd_id = 4'd15; #1;
    chk("R7 rd_ready low pool empty", {31'h0, rd_ready}, 0);
    rd_addr = 4'd3; #1;
    chk("R7 rd_ready high for full entry", {31'h0, rd_ready}, 1);
    rd_valid = 0;
    base = n_rsp;
    do_wr(4'd9, 16'hA5A5);
    repeat (11) @(negedge clk);
    chk("R7 all parked answered", n_rsp - base, 8);

    // R1/R9 clear
    do_rd(4'd10, 4'd1); do_rd(4'd10, 4'd2);
    do_wr(4'd11, 16'h0B0B);
    do_clear();
    @(negedge clk);
    chk("R1 err_dup cleared", {31'h0, err_dup}, 0);
    chk("R1 wr_ready after clear", {31'h0, wr_ready}, 1);
    do_rd(4'd11, 4'd4);
    @(negedge clk);
    chk("R1 entry empty after clear", {31'h0, rsp_valid}, 0);
    base = n_rsp;
    do_wr(4'd10, 16'h7777);
    repeat (4) @(negedge clk);
    chk("R9 stale readers dropped", n_rsp - base, 0);
    do_wr(4'd11, 16'h0C0C);
    repeat (4) @(negedge clk);
    chk("R9 new reader answered", n_rsp - base, 1);

    // constrained random mix
    for (int n = 0; n < 500; n++) begin
      logic [3:0] a;
      int r;
      r = int'($urandom % 100);
      a = 4'($urandom % 16);
      if (r < 30) do_wr(a, 16'($urandom));
      else if (m_full[a] || m_total < 8) do_rd(a, 4'($urandom));
      else do_wr(a, 16'($urandom));
    end
    for (int i = 0; i < 16; i++) if (!m_full[i]) do_wr(4'(i), 16'($urandom));
    repeat (20) @(negedge clk);
    chk("R4 all expected responses seen", exp_id.size(), 0);
    chk("R6 err_dup random", {31'h0, err_dup}, {31'h0, m_err});
    if (m_err) chk("R6 err_addr random", {28'h0, err_addr}, {28'h0, m_eaddr});
    summary();
  end
endmodule